// File: doc/BRIEF.md
# TDMA Burst Power-Control Sequencer

This block drives the per-slot power and routing strobes of a time-division duplex radio front end. Time is counted in bit periods: each pulse on `bitTick` moves a slot-position counter forward by one, and the counter wraps after `SLOT_BITS` positions. A slot is either a transmit slot, a receive slot or an idle slot. A transmit or receive slot carries a burst start position `S`, and the burst spans `BURST_BITS` bits, ending at `E = S + BURST_BITS`.

Every output is a window measured against `S` or `E` in bit times. Transmitter power, PLL lock, amplifier enable, antenna/oscillator routing and data gating are opened ahead of a transmit burst and closed after it. In a transmit slot the PLL is powered up well before the burst and then deliberately powered down shortly before the burst, so that the oscillator can be modulated open-loop. In a receive slot the receiver and PLL are powered up ahead of the burst, and a short DC-offset acquisition window covers the preamble. All power-down outputs are high-true, so a low level means the function is running.

Commands are queued. A command given with `cmdValid` is held until the next slot boundary and only takes effect there. This means a command issued in the middle of a burst does not disturb that burst. Every lead and lag is a build-time parameter. The defaults follow the standard bit counts, and the caller must choose `burstPos` so that every window fits inside the slot.

Top module: `burst_power_seq`

## Requirements
- R1: Out of reset, and throughout an idle slot, the outputs sit in their safe levels: `pllPd`, `txPd` and `rxPd` are 1, `paEn` is 0, `swPos` is 0, `swNeg` is 1, `dcAcqN` is 1 and `txGate` is 0.
- R2: Outputs are registered and change only on a clock edge where `bitTick` is 1. Each tick advances the position by one, from `SLOT_BITS-1` back to 0. In the requirements below, "at position p" means the value after the tick that moves the counter to p. The first tick after reset moves the counter to position 0, and that tick is a slot boundary.
- R3: `slotCmd` encodes 2'b01 as transmit and 2'b10 as receive; 2'b00 and 2'b11 mean idle. A command, together with its `burstPos`, is applied at the next slot boundary. If several commands arrive before that boundary, the last one wins. A slot that had no command queued before its boundary is idle.
- R4: In a transmit slot, `txPd` is 0 at positions in [S-TX_LEAD, E+TX_LAG) and 1 at all other positions.
- R5: In a transmit slot, `pllPd` is 0 at positions in [S-PLL_LEAD, S-PLL_OPEN) and 1 at all other positions, so the loop is open from S-PLL_OPEN onward.
- R6: In a transmit slot, `paEn` is 1 at positions in [S-PA_LEAD, E) and 0 at all other positions.
- R7: `swNeg` is always the inverse of `swPos`. In a transmit slot, `swPos` is 1 (oscillator routed to the amplifier) at positions in [S-SW_LEAD, E+SW_LAG). At all other times, including receive slots, it is 0 (oscillator routed to the receive mixer).
- R8: In a transmit slot, `txGate` is 1 at positions in [S-DATA_LEAD, E+DATA_PAD) and 0 at all other positions.
- R9: In a receive slot, `rxPd` is 0 at positions in [S-RX_LEAD, E) and `pllPd` is 0 at positions in [S-PLL_LEAD, E). Both are 1 at all other positions.
- R10: In a receive slot, `dcAcqN` is 0 at positions in [S-DC_LEAD, S+DC_SPAN) and 1 at all other positions.
- R11: A transmit slot holds `rxPd` and `dcAcqN` at 1. A receive slot holds `txPd` at 1 and holds `paEn` and `txGate` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| bitTick | input | 1 | One-cycle pulse per bit period |
| cmdValid | input | 1 | Captures `slotCmd` and `burstPos` for the next slot |
| slotCmd | input | 2 | Slot kind: 01 transmit, 10 receive, 00/11 idle |
| burstPos | input | POS_W ($clog2(SLOT_BITS)) | Burst start position within the slot |
| pllPd | output | 1 | PLL power-down, high-true |
| txPd | output | 1 | Transmitter power-down, high-true |
| paEn | output | 1 | Power-amplifier enable |
| swPos | output | 1 | Switch line, 1 routes the oscillator to the amplifier |
| swNeg | output | 1 | Inverse of `swPos` |
| rxPd | output | 1 | Receiver power-down, high-true |
| dcAcqN | output | 1 | DC-offset acquisition window, low-true |
| txGate | output | 1 | Transmit-data gating |

## Verification
The bench builds the block with a 96-bit slot and a 16-bit burst. All leads and lags are scaled down (TX_LEAD 40, PLL_LEAD 44, RX_LEAD 12, PA_LEAD 6, SW_LEAD 5, SW_LAG 6, PLL_OPEN 6, DC_LEAD 2, DC_SPAN 8, DATA_LEAD 3, DATA_PAD 3, TX_LAG 3), so that each slot lasts only a few hundred clocks. With these values the bench reaches several corners. One burst start places the PLL lead exactly on position 0. Another places the switch lag end exactly on the slot wrap, so the release comes from the following idle slot. The bench also queues a command during a burst, applies two commands before one boundary, sends the 2'b11 code, and leaves a boundary with no command at all.

// File: rtl/burst_power_seq_pkg.sv
package burst_power_seq_pkg;

  localparam int REL_W = 16;

  typedef enum logic [1:0] {
    SLOT_IDLE = 2'b00,
    SLOT_TX   = 2'b01,
    SLOT_RX   = 2'b10
  } slotKind_t;

  // control -> datapath strobes, values valid for the position being entered
  typedef struct packed {
    logic                    tick;
    slotKind_t               kind;
    logic signed [REL_W-1:0] rel;
  } seqStrobe_t;

  typedef struct packed {
    logic pllPd;
    logic txPd;
    logic paEn;
    logic swPos;
    logic swNeg;
    logic rxPd;
    logic dcAcqN;
    logic txGate;
  } frontEnd_t;

  localparam frontEnd_t FE_SAFE = '{pllPd: 1'b1, txPd: 1'b1, paEn: 1'b0,
                                    swPos: 1'b0, swNeg: 1'b1, rxPd: 1'b1,
                                    dcAcqN: 1'b1, txGate: 1'b0};

  function automatic slotKind_t decodeCmd(input logic [1:0] code);
    case (code)
      2'b01:   return SLOT_TX;
      2'b10:   return SLOT_RX;
      default: return SLOT_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/burst_seq_ctrl.sv
module burst_seq_ctrl
  import burst_power_seq_pkg::*;
#(
  parameter int SLOT_BITS = 1024,
  parameter int POS_W     = $clog2(SLOT_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             cmdValid,
  input  logic [1:0]       slotCmd,
  input  logic [POS_W-1:0] burstPos,
  output seqStrobe_t       strobe
);

  localparam logic [POS_W-1:0] LAST_POS = POS_W'(SLOT_BITS - 1);

  logic [POS_W-1:0] pos, startPos, pendPos;
  logic [POS_W-1:0] posNext, startNext;
  slotKind_t        slot, pendKind, kindNext;
  logic             pendValid;
  logic             atWrap;

  assign atWrap    = (pos == LAST_POS);
  assign posNext   = atWrap ? '0 : pos + 1'b1;
  assign kindNext  = atWrap ? (pendValid ? pendKind : SLOT_IDLE) : slot;
  assign startNext = atWrap ? pendPos : startPos;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pos       <= LAST_POS;
      slot      <= SLOT_IDLE;
      startPos  <= '0;
      pendValid <= 1'b0;
      pendKind  <= SLOT_IDLE;
      pendPos   <= '0;
    end else begin
      if (bitTick) begin
        pos      <= posNext;
        slot     <= kindNext;
        startPos <= startNext;
        if (atWrap) pendValid <= 1'b0;
      end
      if (cmdValid) begin
        pendValid <= 1'b1;
        pendKind  <= decodeCmd(slotCmd);
        pendPos   <= burstPos;
      end
    end
  end

  always_comb begin
    strobe.tick = bitTick;
    strobe.kind = kindNext;
    strobe.rel  = $signed(REL_W'(posNext)) - $signed(REL_W'(startNext));
  end

endmodule

// File: rtl/burst_seq_window.sv
module burst_seq_window
  import burst_power_seq_pkg::*;
#(
  parameter int OPEN  = 0,
  parameter int CLOSE = 1
) (
  input  logic signed [REL_W-1:0] rel,
  output logic                    inWin
);

  localparam logic signed [REL_W-1:0] OPEN_V  = REL_W'(OPEN);
  localparam logic signed [REL_W-1:0] CLOSE_V = REL_W'(CLOSE);

  assign inWin = (rel >= OPEN_V) && (rel < CLOSE_V);

endmodule

// File: rtl/burst_seq_dp.sv
module burst_seq_dp
  import burst_power_seq_pkg::*;
#(
  parameter int BURST_BITS = 424,
  parameter int TX_LEAD    = 460,
  parameter int TX_LAG     = 3,
  parameter int PLL_LEAD   = 461,
  parameter int PLL_OPEN   = 31,
  parameter int PA_LEAD    = 31,
  parameter int SW_LEAD    = 30,
  parameter int SW_LAG     = 31,
  parameter int DATA_LEAD  = 3,
  parameter int DATA_PAD   = 3,
  parameter int RX_LEAD    = 70,
  parameter int DC_LEAD    = 2,
  parameter int DC_SPAN    = 30
) (
  input  logic       clk,
  input  logic       rstN,
  input  seqStrobe_t strobe,
  output frontEnd_t  fe
);

  localparam int N_WIN = 8;
  localparam int W_TX = 0, W_PLLTX = 1, W_PA = 2, W_SW = 3,
                 W_GATE = 4, W_RX = 5, W_PLLRX = 6, W_DC = 7;

  localparam int WIN_OPEN [N_WIN] = '{-TX_LEAD, -PLL_LEAD, -PA_LEAD, -SW_LEAD,
                                      -DATA_LEAD, -RX_LEAD, -PLL_LEAD, -DC_LEAD};
  localparam int WIN_CLOSE[N_WIN] = '{BURST_BITS + TX_LAG, -PLL_OPEN, BURST_BITS,
                                      BURST_BITS + SW_LAG, BURST_BITS + DATA_PAD,
                                      BURST_BITS, BURST_BITS, DC_SPAN};

  logic [N_WIN-1:0] hit;
  frontEnd_t        feNext;

  for (genvar w = 0; w < N_WIN; w++) begin : g_win
    burst_seq_window #(
      .OPEN (WIN_OPEN[w]),
      .CLOSE(WIN_CLOSE[w])
    ) u_win (
      .rel  (strobe.rel),
      .inWin(hit[w])
    );
  end

  always_comb begin
    feNext = FE_SAFE;
    case (strobe.kind)
      SLOT_TX: begin
        feNext.txPd   = !hit[W_TX];
        feNext.pllPd  = !hit[W_PLLTX];
        feNext.paEn   = hit[W_PA];
        feNext.swPos  = hit[W_SW];
        feNext.swNeg  = !hit[W_SW];
        feNext.txGate = hit[W_GATE];
      end
      SLOT_RX: begin
        feNext.rxPd   = !hit[W_RX];
        feNext.pllPd  = !hit[W_PLLRX];
        feNext.dcAcqN = !hit[W_DC];
      end
      default: feNext = FE_SAFE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            fe <= FE_SAFE;
    else if (strobe.tick) fe <= feNext;
  end

endmodule

// File: rtl/burst_power_seq.sv
module burst_power_seq
  import burst_power_seq_pkg::*;
#(
  parameter int SLOT_BITS  = 1024,
  parameter int BURST_BITS = 424,
  parameter int TX_LEAD    = 460,
  parameter int TX_LAG     = 3,
  parameter int PLL_LEAD   = 461,
  parameter int PLL_OPEN   = 31,
  parameter int PA_LEAD    = 31,
  parameter int SW_LEAD    = 30,
  parameter int SW_LAG     = 31,
  parameter int DATA_LEAD  = 3,
  parameter int DATA_PAD   = 3,
  parameter int RX_LEAD    = 70,
  parameter int DC_LEAD    = 2,
  parameter int DC_SPAN    = 30,
  parameter int POS_W      = $clog2(SLOT_BITS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitTick,
  input  logic             cmdValid,
  input  logic [1:0]       slotCmd,
  input  logic [POS_W-1:0] burstPos,
  output logic             pllPd,
  output logic             txPd,
  output logic             paEn,
  output logic             swPos,
  output logic             swNeg,
  output logic             rxPd,
  output logic             dcAcqN,
  output logic             txGate
);

  seqStrobe_t strobe;
  frontEnd_t  fe;

  burst_seq_ctrl #(
    .SLOT_BITS(SLOT_BITS),
    .POS_W    (POS_W)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .bitTick (bitTick),
    .cmdValid(cmdValid),
    .slotCmd (slotCmd),
    .burstPos(burstPos),
    .strobe  (strobe)
  );

  burst_seq_dp #(
    .BURST_BITS(BURST_BITS), .TX_LEAD(TX_LEAD), .TX_LAG(TX_LAG),
    .PLL_LEAD(PLL_LEAD), .PLL_OPEN(PLL_OPEN), .PA_LEAD(PA_LEAD),
    .SW_LEAD(SW_LEAD), .SW_LAG(SW_LAG), .DATA_LEAD(DATA_LEAD),
    .DATA_PAD(DATA_PAD), .RX_LEAD(RX_LEAD), .DC_LEAD(DC_LEAD),
    .DC_SPAN(DC_SPAN)
  ) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .fe    (fe)
  );

  assign pllPd  = fe.pllPd;
  assign txPd   = fe.txPd;
  assign paEn   = fe.paEn;
  assign swPos  = fe.swPos;
  assign swNeg  = fe.swNeg;
  assign rxPd   = fe.rxPd;
  assign dcAcqN = fe.dcAcqN;
  assign txGate = fe.txGate;

endmodule

// File: rtl/burst_power_seq_chk.sv
module burst_power_seq_chk (
  input logic clk,
  input logic rstN,
  input logic bitTick,
  input logic pllPd,
  input logic txPd,
  input logic paEn,
  input logic swPos,
  input logic swNeg,
  input logic rxPd,
  input logic dcAcqN,
  input logic txGate
);

  p_tick_only_r2: assert property (@(posedge clk) disable iff (!rstN)
    !bitTick |=> $stable({pllPd, txPd, paEn, swPos, swNeg, rxPd, dcAcqN, txGate}));

  p_switch_complement_r7: assert property (@(posedge clk) disable iff (!rstN)
    swPos != swNeg);

  p_loop_open_under_pa_r5: assert property (@(posedge clk) disable iff (!rstN)
    paEn |-> pllPd);

  p_pa_needs_tx_r6: assert property (@(posedge clk) disable iff (!rstN)
    paEn |-> !txPd);

  p_gate_needs_tx_r8: assert property (@(posedge clk) disable iff (!rstN)
    txGate |-> !txPd);

  p_dc_needs_rx_r10: assert property (@(posedge clk) disable iff (!rstN)
    !dcAcqN |-> !rxPd);

  p_rx_tx_exclusive_r11: assert property (@(posedge clk) disable iff (!rstN)
    !rxPd |-> (txPd && !paEn && !txGate));

endmodule

bind burst_power_seq burst_power_seq_chk u_chk (
  .clk(clk), .rstN(rstN), .bitTick(bitTick),
  .pllPd(pllPd), .txPd(txPd), .paEn(paEn), .swPos(swPos), .swNeg(swNeg),
  .rxPd(rxPd), .dcAcqN(dcAcqN), .txGate(txGate)
);

// File: tb/burst_power_seq_test.sv
module burst_power_seq_test;

  localparam int SLOT = 96, BURST = 16;
  localparam int TXL = 40, TXG = 3, PLLL = 44, PLLO = 6, PAL = 6;
  localparam int SWL = 5, SWG = 6, DL = 3, DP = 3, RXL = 12, DCL = 2, DCS = 8;
  localparam int PW = $clog2(SLOT);

  logic clk = 1'b0, rstN = 1'b0, bitTick = 1'b0, cmdValid = 1'b0;
  logic [1:0] slotCmd = 2'b00;
  logic [PW-1:0] burstPos = '0;
  logic pllPd, txPd, paEn, swPos, swNeg, rxPd, dcAcqN, txGate;

  always #5 clk = ~clk;

  burst_power_seq #(
    .SLOT_BITS(SLOT), .BURST_BITS(BURST), .TX_LEAD(TXL), .TX_LAG(TXG),
    .PLL_LEAD(PLLL), .PLL_OPEN(PLLO), .PA_LEAD(PAL), .SW_LEAD(SWL),
    .SW_LAG(SWG), .DATA_LEAD(DL), .DATA_PAD(DP), .RX_LEAD(RXL),
    .DC_LEAD(DCL), .DC_SPAN(DCS)
  ) uut (
    .clk(clk), .rstN(rstN), .bitTick(bitTick), .cmdValid(cmdValid),
    .slotCmd(slotCmd), .burstPos(burstPos), .pllPd(pllPd), .txPd(txPd),
    .paEn(paEn), .swPos(swPos), .swNeg(swNeg), .rxPd(rxPd),
    .dcAcqN(dcAcqN), .txGate(txGate)
  );

  int nChecks = 0, nFails = 0;
  bit started = 1'b0, finished = 1'b0;
  string phase = "R1 reset";
  logic [7:0] expQ[$];
  logic [7:0] cur = 8'b1100_1110;   // safe levels (R1)
  logic tickD = 1'b0;

  // model state
  int mPos = SLOT - 1, mKind = 0, mStart = 0;
  int pendK = 0, pendS = 0;
  bit pendV = 1'b0;

  // vector bit order: pllPd txPd paEn swPos swNeg rxPd dcAcqN txGate
  function automatic logic [7:0] expVec(int kind, int s, int p);
    int r = p - s;
    logic [7:0] v = 8'b1100_1110;
    if (kind == 1) begin
      v[6] = !(r >= -TXL && r < BURST + TXG);       // R4
      v[7] = !(r >= -PLLL && r < -PLLO);            // R5
      v[5] = (r >= -PAL && r < BURST);              // R6
      v[4] = (r >= -SWL && r < BURST + SWG);        // R7
      v[3] = !v[4];
      v[0] = (r >= -DL && r < BURST + DP);          // R8
    end else if (kind == 2) begin
      v[2] = !(r >= -RXL && r < BURST);             // R9
      v[7] = !(r >= -PLLL && r < BURST);            // R9
      v[1] = !(r >= -DCL && r < DCS);               // R10
    end
    return v;
  endfunction

  function automatic string reqOf(int b);
    case (b)
      7: return "R5/R9 pllPd";
      6: return "R4 txPd";
      5: return "R6 paEn";
      4: return "R7 swPos";
      3: return "R7 swNeg";
      2: return "R9 rxPd";
      1: return "R10 dcAcqN";
      default: return "R8 txGate";
    endcase
  endfunction

  always_ff @(posedge clk) tickD <= bitTick;

  // monitor
  always @(negedge clk) begin
    if (started && !finished) begin
      logic [7:0] act;
      if (tickD) begin
        if (expQ.size() > 0) cur = expQ.pop_front();
      end
      act = {pllPd, txPd, paEn, swPos, swNeg, rxPd, dcAcqN, txGate};
      nChecks++;
      if (act !== cur) begin
        nFails++;
        for (int b = 7; b >= 0; b--)
          if (act[b] !== cur[b]) begin
            $display("FAIL %s [%s%s] pos=%0d: actual %b expected %b",
                     reqOf(b), phase, tickD ? "" : ", R2 between ticks",
                     mPos, act[b], cur[b]);
            break;
          end
      end
    end
  end

  task automatic doTick();
    bitTick = 1'b1;
    if (mPos == SLOT - 1) begin
      mPos = 0;
      mKind = pendV ? pendK : 0;   // R3
      mStart = pendS;
      pendV = 1'b0;
    end else begin
      mPos++;
    end
    expQ.push_back(expVec(mKind, mStart, mPos));
    @(negedge clk);
    bitTick = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic runTicks(int n);
    for (int i = 0; i < n; i++) doTick();
  endtask

  task automatic sendCmd(logic [1:0] code, int s);
    cmdValid = 1'b1;
    slotCmd = code;
    burstPos = PW'(s);
    pendV = 1'b1;
    pendK = (code == 2'b01) ? 1 : (code == 2'b10) ? 2 : 0;
    pendS = s;
    @(negedge clk);
    cmdValid = 1'b0;
    @(negedge clk);
  endtask

  task automatic finish();
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    started = 1'b1;
    repeat (3) @(negedge clk);
    phase = "R1 idle after reset";
    runTicks(10);
    sendCmd(2'b01, 50);
    runTicks(86);
    phase = "R4 R5 R6 R7 R8 R11 tx s=50";
    runTicks(60);
    phase = "R3 rx queued mid-burst, tx continues";
    sendCmd(2'b10, 44);
    runTicks(36);
    phase = "R9 R10 R11 rx s=44";
    runTicks(20);
    sendCmd(2'b11, 10);
    runTicks(76);
    phase = "R3 code 11 gives idle";
    runTicks(5);
    sendCmd(2'b10, 60);
    sendCmd(2'b01, 74);
    runTicks(91);
    phase = "R3 last command wins, R7 lag at slot end s=74";
    runTicks(96);
    phase = "R3 no command gives idle";
    runTicks(30);
    sendCmd(2'b01, 44);
    runTicks(66);
    phase = "R5 tx s=44 PLL lead at position 0";
    runTicks(96);
    phase = "R1 idle tail";
    runTicks(4);
    finish();
  end

  initial begin
    #2000000;
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog expired [%s]: actual running expected done", phase);
      finish();
    end
  end

endmodule